// File: doc/BRIEF.md
# Serial Wiper Code Register

This block is the digital front of a 256-step programmable resistor. A host writes an 8-bit position code over a three-wire, receive-only serial link: an active-low select, a serial clock and a data line. While select is low, each rising serial clock edge shifts one data bit in, most significant bit first. The assembled word moves into the wiper register only when select goes high again, so the code never changes in the middle of a shift.

The serial pins are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and the edges are found in the system domain. For this reason the system clock must run at least four times faster than the serial clock. The wiper register drives the current code and a registered one-hot tap select of 256 lines for a downstream switch array. A one-cycle strobe marks each new commit. Code 0 closes the tap at the low end of the string. Code 255 closes the highest tap, which lies one segment short of the far end.

Top module: `spi_wiper_reg`

## Requirements
- R1: After reset the code output is 0x80 (midscale), tap line 128 alone is high and the update strobe is low.
- R2: Bits are sampled on rising serial clock edges while select is low, most significant bit first. The code output keeps its old value until select rises.
- R3: If a frame carries more than eight bits, the last eight bits received form the committed code and all earlier bits are dropped.
- R4: A frame of fewer than eight bits leaves the code and tap outputs unchanged and produces no update strobe.
- R5: Serial clock edges while select is high change neither the code output nor the strobe.
- R6: A falling select clears the partial word and bit count. Two short frames that add up to eight bits therefore commit nothing.
- R7: Each commit raises the update strobe for exactly one system clock cycle, and the strobe occurs in the same cycle as the new code.
- R8: Tap line i is high exactly when the code equals i: code 0x00 selects line 0 and code 0xFF selects line 255.
- R9: The tap output is always one-hot and matches the code output in every cycle.
- R10: A serial clock rise that reaches the synchroniser together with the select rise is not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, sampled on its rising edge |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, most significant bit first |
| code_o | output | 8 | Committed wiper code |
| tap_sel_o | output | 256 | One-hot tap select, line i for code i |
| update_o | output | 1 | One-cycle strobe on each commit |

## Verification
A serial clock rise and the select rise can land on the same synchronised cycle. That cycle must end the frame and must not add a ninth bit. The bench provokes this by driving both pins high on the same system clock edge after eight valid bits. The committed code must be the eight-bit word sent, not that word shifted by one extra bit. In the same way, a select fall and a clock edge never meet inside a frame under the required clock ratio, so the bench judges R6 only through frame pairs.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    localparam int CODE_W = 8;
    localparam int TAPS   = 1 << CODE_W;
    localparam int CNT_W  = $clog2(CODE_W + 1);
    localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(1 << (CODE_W - 1));
    localparam logic [CNT_W-1:0]  CNT_FULL   = CNT_W'(CODE_W);

    typedef struct packed {
        logic [CODE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              clk_prev;
        logic              sel_prev;
    } shift_st_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [TAPS-1:0]   tap;
        logic              upd;
    } wiper_st_t;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import wiper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sel_s,
    input  logic              din_s,
    output logic              commit_o,
    output logic [CODE_W-1:0] word_o
);
    localparam shift_st_t RESET_ST = '{shreg: '0, cnt: '0, clk_prev: 1'b0, sel_prev: 1'b1};

    shift_st_t st_d, st_q;
    logic clk_rise, sel_fall, sel_rise;

    always_comb begin
        st_d     = st_q;
        clk_rise = sclk_s && !st_q.clk_prev;
        sel_fall = !sel_s && st_q.sel_prev;
        sel_rise = sel_s && !st_q.sel_prev;
        st_d.clk_prev = sclk_s;
        st_d.sel_prev = sel_s;
        // Start of frame: drop any partial word.
        if (sel_fall) begin
            st_d.shreg = '0;
            st_d.cnt   = '0;
        end
        // Sample only while selected; older bits fall off the top.
        if (!sel_s && clk_rise) begin
            st_d.shreg = {st_d.shreg[CODE_W-2:0], din_s};
            if (st_d.cnt != CNT_FULL) st_d.cnt = st_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign commit_o = sel_rise && (st_q.cnt == CNT_FULL);
    assign word_o   = st_q.shreg;
endmodule

// File: rtl/wiper_register.sv
module wiper_register
    import wiper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [CODE_W-1:0] word_i,
    output logic [CODE_W-1:0] code_o,
    output logic [TAPS-1:0]   tap_o,
    output logic              upd_o
);
    localparam wiper_st_t RESET_ST = '{code: RESET_CODE, tap: TAPS'(1) << RESET_CODE, upd: 1'b0};

    wiper_st_t       st_d, st_q;
    logic [TAPS-1:0] dec;

    for (genvar i = 0; i < TAPS; i++) begin : g_dec
        assign dec[i] = (word_i == CODE_W'(i));
    end

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (commit_i) begin
            st_d.code = word_i;
            st_d.tap  = dec;
            st_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign tap_o  = st_q.tap;
    assign upd_o  = st_q.upd;
endmodule

// File: rtl/spi_wiper_reg.sv
module spi_wiper_reg
    import wiper_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel_n,
    input  logic              ser_din,
    output logic [CODE_W-1:0] code_o,
    output logic [TAPS-1:0]   tap_sel_o,
    output logic              update_o
);
    localparam int PIN_CLK = 0;
    localparam int PIN_SEL = 1;
    localparam int PIN_DIN = 2;

    logic [2:0]        pins_sync;
    logic              sel_sync;
    logic              commit;
    logic [CODE_W-1:0] word;

    serial_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({ser_din, ser_sel_n, ser_clk}),
        .sync_o (pins_sync)
    );

    assign sel_sync = pins_sync[PIN_SEL];

    frame_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_sync[PIN_CLK]),
        .sel_s   (sel_sync),
        .din_s   (pins_sync[PIN_DIN]),
        .commit_o(commit),
        .word_o  (word)
    );

    wiper_register u_wiper (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit),
        .word_i  (word),
        .code_o  (code_o),
        .tap_o   (tap_sel_o),
        .upd_o   (update_o)
    );
endmodule

// File: rtl/spi_wiper_reg_chk.sv
module spi_wiper_reg_chk
    import wiper_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_o,
    input logic [TAPS-1:0]   tap_sel_o,
    input logic              update_o,
    input logic              sel_sync
);
    assert_reset_mid_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (code_o == RESET_CODE && tap_sel_o[RESET_CODE] && !update_o));

    assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> $stable(code_o));

    assert_commit_after_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> $past(sel_sync));

    assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    assert_tap_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_o) == 1);

    assert_tap_matches_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel_o[code_o]);
endmodule

bind spi_wiper_reg spi_wiper_reg_chk u_chk (.*);

// File: tb/spi_wiper_reg_tb.sv
module spi_wiper_reg_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_sel_n = 1'b1;
    logic         ser_din = 1'b0;
    logic [7:0]   code_o;
    logic [255:0] tap_sel_o;
    logic         update_o;

    int checks = 0;
    int fails  = 0;
    int upd_cnt = 0;
    int wide_pulse = 0;
    logic upd_prev = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_wiper_reg u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_sel_n(ser_sel_n),
        .ser_din  (ser_din),
        .code_o   (code_o),
        .tap_sel_o(tap_sel_o),
        .update_o (update_o)
    );

    always @(negedge clk) begin
        if (update_o) upd_cnt++;
        if (update_o && upd_prev) wide_pulse++;
        upd_prev <= update_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;
        cyc(4);
        ser_clk = 1'b1;
        cyc(4);
        ser_clk = 1'b0;
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        ser_sel_n = 1'b0;
        cyc(4);
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
        cyc(4);
        ser_sel_n = 1'b1;
        cyc(8);
    endtask

    task automatic check_code(input logic [7:0] exp, input string req);
        chk(code_o == exp, req, code_o, exp);
        chk(tap_sel_o[exp] && $countones(tap_sel_o) == 1, req, $countones(tap_sel_o), 1);
    endtask

    task automatic t_reset;
        check_code(8'h80, "R1");
        chk(update_o == 1'b0, "R1", update_o, 0);
    endtask

    task automatic t_msb_first;
        int u0 = upd_cnt;
        ser_sel_n = 1'b0;
        cyc(4);
        for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i);
        cyc(8);
        chk(code_o == 8'h80, "R2 held until select rise", code_o, 8'h80);
        ser_sel_n = 1'b1;
        cyc(8);
        check_code(8'hA5, "R2");
        chk(upd_cnt == u0 + 1, "R7 strobe count", upd_cnt - u0, 1);
    endtask

    task automatic t_ends;
        frame(32'h00, 8);
        check_code(8'h00, "R8 code zero");
        chk(tap_sel_o[0], "R8 line 0", tap_sel_o[0], 1);
        frame(32'hFF, 8);
        check_code(8'hFF, "R8 code full");
        chk(tap_sel_o[255], "R8 line 255", tap_sel_o[255], 1);
    endtask

    task automatic t_overlong;
        frame(32'hF3C, 12);
        check_code(8'h3C, "R3");
    endtask

    task automatic t_short;
        int u0 = upd_cnt;
        frame(32'h15, 5);
        check_code(8'h3C, "R4");
        chk(upd_cnt == u0, "R4 no strobe", upd_cnt - u0, 0);
    endtask

    task automatic t_clear;
        int u0 = upd_cnt;
        frame(32'h1B, 5);
        frame(32'h5, 3);
        check_code(8'h3C, "R6");
        chk(upd_cnt == u0, "R6 no strobe", upd_cnt - u0, 0);
    endtask

    task automatic t_idle_clocks;
        int u0 = upd_cnt;
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        cyc(8);
        check_code(8'h3C, "R5");
        chk(upd_cnt == u0, "R5 no strobe", upd_cnt - u0, 0);
        frame(32'h5A, 8);
        check_code(8'h5A, "R5 next frame");
    endtask

    task automatic t_coincide;
        ser_sel_n = 1'b0;
        cyc(4);
        for (int i = 7; i >= 0; i--) send_bit(8'hC3 >> i);
        ser_din = 1'b1;
        cyc(4);
        ser_clk   = 1'b1;
        ser_sel_n = 1'b1;
        cyc(4);
        ser_clk = 1'b0;
        cyc(8);
        check_code(8'hC3, "R10");
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_msb_first();
        t_ends();
        t_overlong();
        t_short();
        t_clear();
        t_idle_clocks();
        t_coincide();
        chk(wide_pulse == 0, "R7 strobe width", wide_pulse, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule